// File: doc/BRIEF.md
# Multi-Channel Match-Compare Timer

A register-mapped timer unit holding three independent 32-bit up-counters. Each counter drives three equality comparators. Each comparator owns a sticky status bit that software clears by writing ones, and an enable mask chooses which status bits drive that timer's interrupt line. A per-timer mode bit picks one of two behaviours. In free-running mode the counter wraps at 2^32. In periodic mode comparator 0 reloads the counter from a per-timer reload register. Software never reads a live counter. A write to the timer's snapshot register latches the count, and a later read of that register returns the latched value.

The block sits on a simple synchronous register bus. A write takes effect at the clock edge on which `we_i` is high. A read is combinational: `rdata_o` reflects the addressed register while `re_i` is high. The address splits into a 4-bit group field `addr_i[7:4]` and a 4-bit register offset `addr_i[3:0]`. Group 0, offset 0 is the run register. Group t+1 holds the registers of timer t, at these offsets:

| Offset | Register |
|--------|----------|
| 0, 1, 2 | match values for comparators 0, 1, 2 |
| 3 | reload value |
| 4 | mode |
| 5 | interrupt mask |
| 6 | status |
| 7 | snapshot |

Top module: `match_timer_unit`

## Requirements
- R1: After `rst_ni` is asserted low, every register reads 0 and every `irq_o` bit is 0.
- R2: The run register sits at address 0x00, and bit t runs timer t. A running counter in free-running mode adds 1 per clock and wraps from 0xFFFFFFFF to 0.
- R3: A run-register write that sets bit t while that bit was clear restarts counter t at 0. A counter whose bit is clear holds its value. Writing 1 to a bit that is already set does not restart the counter.
- R4: While timer t runs, status bit k sets at the clock edge where the count equals match value k. A match value M therefore sets the bit M+1 edges after the restarting write.
- R5: A status bit stays set until a write of 1 to that bit at offset 6. Bits written 0 are unaffected. A match on the same edge as a clearing write leaves the bit set. A read at offset 6 returns the status bits in [2:0].
- R6: `irq_o[t]` is 1 exactly when a status bit of timer t and the matching mask bit at offset 5 (bits [2:0]) are both set.
- R7: Mode bit 0 at offset 4 selects the counting behaviour. When it is 1, the counter loads the reload value (offset 3) on the edge where the count equals match value 0. When it is 0, no match reloads the counter.
- R8: Any write to offset 7 latches the timer's count as it stood before that edge. Reads at offset 7 return the latched value, not the live count.
- R9: Reads of unmapped addresses return 0. Unmapped addresses are group 0 with a non-zero offset, offsets 8 to 15, and groups above 3. `rdata_o` is 0 whenever `re_i` is low.
- R10: A stopped timer sets no new status bits, even when its held count equals a match value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | 8 | Register address, group in [7:4] and offset in [3:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 when `re_i` is low |
| irq_o | output | 3 | One interrupt per timer |

## Verification
A wrong count shows up only through the snapshot path, so the bench captures the counter on consecutive edges. Each latched value is checked against a count derived from the restart edge. An off-by-one step, a missed reload or a missed wrap therefore appears at the first read that follows it. A wrong status bit shows up on `irq_o` in the same cycle once its mask bit is set, and at the status offset on any read. A clear that removes the wrong bit, or a match lost under a clear, is visible one edge after the write.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int OFF_W = 4;
  localparam logic [OFF_W-1:0] OFF_RELOAD = 4'd3;
  localparam logic [OFF_W-1:0] OFF_MODE   = 4'd4;
  localparam logic [OFF_W-1:0] OFF_MASK   = 4'd5;
  localparam logic [OFF_W-1:0] OFF_STS    = 4'd6;
  localparam logic [OFF_W-1:0] OFF_SNAP   = 4'd7;
endpackage

// File: rtl/mtu_counter.sv
module mtu_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (restart_i) cnt_o <= '0;
    else if (run_i)     cnt_o <= reload_i ? reload_val_i : cnt_o + 1'b1;
  end
endmodule

// File: rtl/mtu_cmp_bank.sv
module mtu_cmp_bank #(
  parameter int N_CMP = 3,
  parameter int CNT_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [N_CMP-1:0][CNT_W-1:0] match_i,
  input  logic [N_CMP-1:0]            clr_i,
  output logic [N_CMP-1:0]            hit_o,
  output logic [N_CMP-1:0]            sts_o
);
  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign hit_o[k] = run_i && (cnt_i == match_i[k]);
    // set beats clear on the same edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_o[k] <= 1'b0;
      else         sts_o[k] <= (sts_o[k] & ~clr_i[k]) | hit_o[k];
    end
  end
endmodule

// File: rtl/mtu_channel.sv
module mtu_channel
  import mtu_pkg::*;
#(
  parameter int N_CMP = 3,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [N_CMP-1:0] sts_o,
  output logic [CNT_W-1:0] match0_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             periodic_o
);
  logic [N_CMP-1:0][CNT_W-1:0] match_q;
  logic [CNT_W-1:0]            reload_q;
  logic [CNT_W-1:0]            snap_q;
  logic [N_CMP-1:0]            mask_q;
  logic                        periodic_q;
  logic [N_CMP-1:0]            hit;
  logic [N_CMP-1:0]            clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q    <= '0;
      reload_q   <= '0;
      snap_q     <= '0;
      mask_q     <= '0;
      periodic_q <= 1'b0;
    end else if (wr_i) begin
      for (int k = 0; k < N_CMP; k++)
        if (off_i == OFF_W'(k)) match_q[k] <= wdata_i;
      case (off_i)
        OFF_RELOAD: reload_q   <= wdata_i;
        OFF_MODE:   periodic_q <= wdata_i[0];
        OFF_MASK:   mask_q     <= wdata_i[N_CMP-1:0];
        OFF_SNAP:   snap_q     <= cnt_o;
        default: ;
      endcase
    end
  end

  assign clr = (wr_i && off_i == OFF_STS) ? wdata_i[N_CMP-1:0] : '0;

  mtu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .restart_i    (restart_i),
    .reload_i     (periodic_q && hit[0]),
    .reload_val_i (reload_q),
    .cnt_o        (cnt_o)
  );

  mtu_cmp_bank #(.N_CMP(N_CMP), .CNT_W(CNT_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .cnt_i   (cnt_o),
    .match_i (match_q),
    .clr_i   (clr),
    .hit_o   (hit),
    .sts_o   (sts_o)
  );

  assign irq_o      = |(sts_o & mask_q);
  assign match0_o   = match_q[0];
  assign reload_o   = reload_q;
  assign periodic_o = periodic_q;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_CMP; k++)
      if (off_i == OFF_W'(k)) rdata_o = match_q[k];
    case (off_i)
      OFF_RELOAD: rdata_o = reload_q;
      OFF_MODE:   rdata_o = CNT_W'(periodic_q);
      OFF_MASK:   rdata_o = CNT_W'(mask_q);
      OFF_STS:    rdata_o = CNT_W'(sts_o);
      OFF_SNAP:   rdata_o = snap_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/match_timer_unit.sv
module match_timer_unit
  import mtu_pkg::*;
#(
  parameter int N_TIMERS = 3,
  parameter int N_CMP    = 3,  // at most 3: offsets 3..7 are fixed
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]    rdata_o,
  output logic [N_TIMERS-1:0] irq_o
);
  localparam int SEL_W = ADDR_W - OFF_W;

  logic [SEL_W-1:0]                   sel;
  logic [OFF_W-1:0]                   off;
  logic                               run_wr;
  logic [N_TIMERS-1:0]                run_q;
  logic [N_TIMERS-1:0]                restart;
  logic [N_TIMERS-1:0][CNT_W-1:0]     ch_rdata;
  logic [N_TIMERS-1:0][CNT_W-1:0]     cnt_all;
  logic [N_TIMERS-1:0][N_CMP-1:0]     sts_all;
  logic [N_TIMERS-1:0][CNT_W-1:0]     match0_all;
  logic [N_TIMERS-1:0][CNT_W-1:0]     reload_all;
  logic [N_TIMERS-1:0]                periodic_all;

  assign sel     = addr_i[ADDR_W-1:OFF_W];
  assign off     = addr_i[OFF_W-1:0];
  assign run_wr  = we_i && sel == '0 && off == '0;
  assign restart = run_wr ? (wdata_i[N_TIMERS-1:0] & ~run_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (run_wr) run_q <= wdata_i[N_TIMERS-1:0];
  end

  for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
    mtu_channel #(.N_CMP(N_CMP), .CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q[t]),
      .restart_i  (restart[t]),
      .wr_i       (we_i && sel == SEL_W'(t + 1)),
      .off_i      (off),
      .wdata_i    (wdata_i),
      .rdata_o    (ch_rdata[t]),
      .irq_o      (irq_o[t]),
      .cnt_o      (cnt_all[t]),
      .sts_o      (sts_all[t]),
      .match0_o   (match0_all[t]),
      .reload_o   (reload_all[t]),
      .periodic_o (periodic_all[t])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (sel == '0 && off == '0) rdata_o = CNT_W'(run_q);
      for (int t = 0; t < N_TIMERS; t++)
        if (sel == SEL_W'(t + 1)) rdata_o = ch_rdata[t];
    end
  end
endmodule

// File: rtl/mtu_chk.sv
module mtu_chk
  import mtu_pkg::*;
#(
  parameter int N_TIMERS = 3,
  parameter int N_CMP    = 3,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            we_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [CNT_W-1:0]                wdata_i,
  input logic [N_TIMERS-1:0]             irq_o,
  input logic [N_TIMERS-1:0]             run_q,
  input logic [N_TIMERS-1:0][CNT_W-1:0]  cnt_all,
  input logic [N_TIMERS-1:0][N_CMP-1:0]  sts_all,
  input logic [N_TIMERS-1:0][CNT_W-1:0]  match0_all,
  input logic [N_TIMERS-1:0][CNT_W-1:0]  reload_all,
  input logic [N_TIMERS-1:0]             periodic_all
);
  logic run_wr;
  assign run_wr = we_i && addr_i == '0;

  for (genvar t = 0; t < N_TIMERS; t++) begin : g_t
    logic sts_wr;
    assign sts_wr = we_i && addr_i == ADDR_W'(((t + 1) << OFF_W) + int'(OFF_STS));

    p_irq_has_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[t] |-> sts_all[t] != '0);

    p_hold_when_stopped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q[t] && !run_wr |=> $stable(cnt_all[t]));

    p_free_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q[t] && !periodic_all[t] |=> cnt_all[t] == CNT_W'($past(cnt_all[t]) + 1));

    p_reload_on_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q[t] && periodic_all[t] && cnt_all[t] == match0_all[t]
      |=> cnt_all[t] == $past(reload_all[t]));

    for (genvar k = 0; k < N_CMP; k++) begin : g_k
      p_status_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sts_all[t][k] && !(sts_wr && wdata_i[k]) |=> sts_all[t][k]);

      p_no_status_stopped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_q[t] && !sts_all[t][k] |=> !sts_all[t][k]);
    end
  end
endmodule

bind match_timer_unit mtu_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .irq_o        (irq_o),
  .run_q        (run_q),
  .cnt_all      (cnt_all),
  .sts_all      (sts_all),
  .match0_all   (match0_all),
  .reload_all   (reload_all),
  .periodic_all (periodic_all)
);

// File: tb/sim_match_timer_unit.sv
module sim_match_timer_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  match_timer_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] ra(input int t, input int off);
    return 8'(((t + 1) << 4) | off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; re_i = 1'b1;
    #1 d = rdata_o;
    re_i = 1'b0;
  endtask

  task automatic do_reset();
    we_i = 1'b0; re_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h00, d);       chk("R1 run reg", d, 0);
    rd(ra(2, 0), d);    chk("R1 match", d, 0);
    rd(ra(0, 6), d);    chk("R1 status", d, 0);
    chk("R1 irq", 32'(irq_o), 0);
    repeat (3) @(negedge clk_i);
    wr(ra(1, 7), 0);
    rd(ra(1, 7), d);    chk("R1 counter idle", d, 0);
  endtask

  task automatic t_match();
    logic [31:0] d;
    do_reset();
    wr(ra(0, 0), 100); wr(ra(0, 1), 5); wr(ra(0, 2), 200);
    wr(ra(0, 5), 32'h2);
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk_i);
    rd(ra(0, 6), d);    chk("R4 before match", d, 0);
    chk("R6 irq before", 32'(irq_o[0]), 0);
    @(negedge clk_i);
    rd(ra(0, 6), d);    chk("R4 match sets bit1", d, 32'h2);
    chk("R6 irq on masked status", 32'(irq_o[0]), 1);
    repeat (3) @(negedge clk_i);
    rd(ra(0, 6), d);    chk("R5 sticky", d, 32'h2);
    wr(ra(0, 5), 0);
    chk("R6 irq masked off", 32'(irq_o[0]), 0);
    wr(ra(0, 6), 32'h1);
    rd(ra(0, 6), d);    chk("R5 clear other bit", d, 32'h2);
    wr(ra(0, 6), 32'h7);
    rd(ra(0, 6), d);    chk("R5 clear all", d, 0);
    wr(8'h00, 0);
    wr(8'h00, 32'h1);
    repeat (5) @(negedge clk_i);
    wr(ra(0, 6), 32'h2);
    rd(ra(0, 6), d);    chk("R5 match beats clear", d, 32'h2);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    do_reset();
    wr(8'h00, 32'h1);
    repeat (3) @(negedge clk_i);
    wr(8'h00, 32'h1);
    wr(ra(0, 7), 0);
    rd(ra(0, 7), d);    chk("R3 no restart when already set", d, 4);
    wr(8'h00, 0);
    repeat (4) @(negedge clk_i);
    wr(ra(0, 7), 0);
    rd(ra(0, 7), d);    chk("R3 hold while stopped", d, 6);
    wr(ra(0, 6), 32'h7);
    wr(ra(0, 2), 6);
    repeat (3) @(negedge clk_i);
    rd(ra(0, 6), d);    chk("R10 no status while stopped", d, 0);
    wr(8'h00, 32'h1);
    wr(ra(0, 7), 0);
    rd(ra(0, 7), d);    chk("R3 restart at zero", d, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    do_reset();
    wr(ra(1, 0), 3); wr(ra(1, 4), 1);
    wr(8'h00, 32'h2);
    repeat (3) @(negedge clk_i);
    wr(ra(1, 7), 0);
    rd(ra(1, 7), d);    chk("R8 snapshot at match", d, 3);
    wr(ra(1, 7), 0);
    rd(ra(1, 7), d);    chk("R7 reload to zero", d, 0);
    repeat (4) @(negedge clk_i);
    rd(ra(1, 7), d);    chk("R8 latched not live", d, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    do_reset();
    wr(ra(2, 3), 32'hFFFF_FFFD); wr(ra(2, 0), 1); wr(ra(2, 4), 1);
    wr(8'h00, 32'h4);
    repeat (2) @(negedge clk_i);
    wr(ra(2, 4), 0);
    wr(ra(2, 7), 0);
    rd(ra(2, 7), d);    chk("R7 reload value", d, 32'hFFFF_FFFE);
    wr(ra(2, 7), 0);
    rd(ra(2, 7), d);    chk("R2 top count", d, 32'hFFFF_FFFF);
    wr(ra(2, 7), 0);
    rd(ra(2, 7), d);    chk("R2 wrap to zero", d, 0);
    wr(ra(2, 7), 0);
    wr(ra(2, 7), 0);
    rd(ra(2, 7), d);    chk("R7 free mode passes match0", d, 2);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_reset();
    wr(ra(0, 0), 32'hA5A5_0001);
    rd(8'h0F, d);       chk("R9 group0 offset", d, 0);
    rd(8'h48, d);       chk("R9 group above", d, 0);
    rd(ra(0, 9), d);    chk("R9 high offset", d, 0);
    addr_i = ra(0, 0); re_i = 1'b0;
    #1 chk("R9 no read strobe", rdata_o, 0);
    rd(ra(0, 0), d);    chk("R9 mapped read still works", d, 32'hA5A5_0001);
  endtask

  initial begin
    t_reset();
    t_match();
    t_restart();
    t_periodic();
    t_wrap();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule